// File: doc/BRIEF.md
# Stream Cipher Phase Sequencer

This block is the control unit of a word-serial stream-cipher coprocessor built around a five-word state block. It takes in secret-key and nonce words from a 32-bit input bus and tells a separate arithmetic datapath what to do. The datapath itself is not part of this block. It receives load strobes with a register selector and a data word, and it receives block start pulses tagged with a mode. It answers every started block with a single `blk_done` pulse. The host has no handshake. The host therefore presents key and nonce words on fixed consecutive cycles, and it presents data words on the cycles in which a data block is issued.

A full session runs through these phases in order: key input, key mixing, initialisation, a stream of encrypt or decrypt blocks, and tag generation. The block then waits for the host. The mixed key is retained after a session. The next message therefore only reloads the nonce and goes straight to initialisation. Changing the key requires a reset. The number of blocks in each fixed-length phase is counted from datapath completions, so each phase stops after exactly the number of blocks it needs.

Top module: `phx_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `ld_stb`, `blk_go`, `blk_mode` and `dp_bus` are all zero, and no load or block start follows until `en` is raised.
- R2: With no key held, raising `en` in the idle phase leads to twelve load strobes on twelve consecutive cycles with `ld_sel` 0 to 11. Selectors 0 to 7 are key words and 8 to 11 are nonce words. Each strobe carries the `din` value sampled on the clock edge that produced it.
- R3: Key mixing starts with one load strobe with `ld_sel` 13 (Z4 seed) and data 96. It then issues exactly eight blocks with `blk_mode` 1. A load strobe and a block start never occur in the same cycle.
- R4: Initialisation starts with one load strobe with `ld_sel` 14 (key/nonce combine and clear feedback) and data 0. It then issues exactly eight blocks with `blk_mode` 2 and data 0.
- R5: After initialisation, `dec_sel` low gives data blocks with `blk_mode` 3 (encrypt) and `dec_sel` high gives `blk_mode` 4 (decrypt). While `en` is high, one block is issued per completed block, and `dp_bus` carries the `din` value present at the issuing edge.
- R6: At most one block is outstanding. `blk_go` is a single-cycle pulse, and no new block starts before `blk_done` answers the previous one.
- R7: When `en` is low once no block is outstanding in the data phase, the tag phase starts. It begins with one load strobe with `ld_sel` 12 (Z0 XOR) and data 0x912d94f1. It then issues eight blocks with `blk_mode` 5 (output discarded), followed by four blocks with `blk_mode` 6 (tag words).
- R8: All twelve tag-phase blocks carry the final-word byte count on `dp_bus`. This count is `last_bytes` sampled when the message ends. Values 4 to 7 are clamped to 3.
- R9: After the tag phase, no strobe is produced while `en` stays high. Lowering `en` returns to idle. The next rise of `en` loads only four nonce words (`ld_sel` 8 to 11) and proceeds to initialisation without key mixing.
- R10: Lowering `en` during nonce input abandons it with no further strobe. The next rise of `en` restarts nonce input at `ld_sel` 8.
- R11: A reset from any phase returns to idle and discards the mixed key. The next rise of `en` runs the full twelve-word key input.
- R12: A `blk_done` pulse that arrives when no block is outstanding is ignored. It causes no load strobe and no block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Session enable; its level steers phase changes |
| dec_sel | input | 1 | 0 = encrypt, 1 = decrypt; sampled when initialisation ends |
| last_bytes | input | 3 | Byte count of the final data word; sampled when the message ends |
| din | input | 32 | Key, nonce and data word input |
| blk_done | input | 1 | Datapath pulse marking completion of the outstanding block |
| ld_stb | output | 1 | Load strobe to the datapath |
| ld_sel | output | 4 | Load target selector |
| blk_go | output | 1 | Block start pulse |
| blk_mode | output | 3 | Mode of the block being started (0 when idle) |
| dp_bus | output | 32 | Load word or block data word |

## Verification
The most delicate collision is the end of a message. Here `en` falls while a data block is still outstanding, and that block's `blk_done` then returns on a later edge. The edge that retires the last data block must neither issue an extra data block nor skip straight into the tag phase without its Z0 load. The bench provokes this in every message of a sweep over both cipher directions, message lengths 0 to 3 and all eight byte-count codes. It judges the result by the exact sequence of loads and block starts that follows. A second collision injects a stray completion pulse while no block is outstanding, and the bench then checks that the ports stay quiet.

// File: rtl/phx_pkg.sv
package phx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_KEYIN = 4'd1,
    ST_MIX   = 4'd2,
    ST_INIT  = 4'd3,
    ST_ENC   = 4'd4,
    ST_DEC   = 4'd5,
    ST_MAC   = 4'd6,
    ST_DWAIT = 4'd7,
    ST_NONCE = 4'd8
  } phx_st_e;

  localparam int unsigned MODE_W = 3;

  localparam logic [MODE_W-1:0] MD_NONE = 3'd0;
  localparam logic [MODE_W-1:0] MD_MIX  = 3'd1;
  localparam logic [MODE_W-1:0] MD_INIT = 3'd2;
  localparam logic [MODE_W-1:0] MD_ENC  = 3'd3;
  localparam logic [MODE_W-1:0] MD_DEC  = 3'd4;
  localparam logic [MODE_W-1:0] MD_MACD = 3'd5;
  localparam logic [MODE_W-1:0] MD_TAG  = 3'd6;

  localparam int unsigned MIX_SEED  = 96;
  localparam logic [31:0] TAG_XOR_C = 32'h912d94f1;

endpackage

// File: rtl/phx_cnt.sv
module phx_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && (q == '1)) |-> clr);  // R7

endmodule

// File: rtl/phx_blk_issue.sv
module phx_blk_issue (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic done_in,
  output logic go,
  output logic ready,
  output logic done_ok
);

  logic busy;

  assign ready   = !busy;
  assign done_ok = done_in && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      go   <= 1'b0;
      busy <= 1'b0;
    end else begin
      go <= req && !busy;
      if (req && !busy) busy <= 1'b1;
      else if (done_in) busy <= 1'b0;
    end
  end

  AST_GO_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
    go |-> $past(!busy));  // R6

endmodule

// File: rtl/phx_seq_ctrl.sv
module phx_seq_ctrl
  import phx_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned KEY_WORDS   = 8,
  parameter int unsigned NONCE_WORDS = 4,
  parameter int unsigned MIX_BLOCKS  = 8,
  parameter int unsigned INIT_BLOCKS = 8,
  parameter int unsigned MAC_SKIP    = 8,
  parameter int unsigned TAG_WORDS   = 4,
  parameter int unsigned INFO_W      = 3,
  parameter int unsigned INFO_MAX    = 3,
  parameter int unsigned SEL_W       = $clog2(KEY_WORDS + NONCE_WORDS + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              dec_sel,
  input  logic [INFO_W-1:0] last_bytes,
  input  logic [DW-1:0]     din,
  input  logic              blk_done,
  output logic              ld_stb,
  output logic [SEL_W-1:0]  ld_sel,
  output logic              blk_go,
  output logic [MODE_W-1:0] blk_mode,
  output logic [DW-1:0]     dp_bus
);

  localparam int unsigned LOAD_WORDS = KEY_WORDS + NONCE_WORDS;
  localparam int unsigned MAC_BLOCKS = MAC_SKIP + TAG_WORDS;
  localparam int unsigned MAX_MI     = (MIX_BLOCKS > INIT_BLOCKS) ? MIX_BLOCKS : INIT_BLOCKS;
  localparam int unsigned MAXB       = (MAC_BLOCKS > MAX_MI) ? MAC_BLOCKS : MAX_MI;
  localparam int unsigned WC_W       = $clog2(LOAD_WORDS + 1);
  localparam int unsigned BC_W       = $clog2(MAXB + 1);
  localparam int unsigned IW         = $clog2(INFO_MAX + 1);

  localparam logic [WC_W-1:0]  KEY_LAST   = WC_W'(LOAD_WORDS - 1);
  localparam logic [WC_W-1:0]  NONCE_LAST = WC_W'(NONCE_WORDS - 1);
  localparam logic [BC_W-1:0]  MIX_LAST   = BC_W'(MIX_BLOCKS - 1);
  localparam logic [BC_W-1:0]  INIT_LAST  = BC_W'(INIT_BLOCKS - 1);
  localparam logic [BC_W-1:0]  MAC_LAST   = BC_W'(MAC_BLOCKS - 1);
  localparam logic [BC_W-1:0]  SKIP_N     = BC_W'(MAC_SKIP);
  localparam logic [SEL_W-1:0] SEL_Z0X    = SEL_W'(LOAD_WORDS);
  localparam logic [SEL_W-1:0] SEL_Z4     = SEL_W'(LOAD_WORDS + 1);
  localparam logic [SEL_W-1:0] SEL_INIT   = SEL_W'(LOAD_WORDS + 2);
  localparam logic [SEL_W-1:0] SEL_NBASE  = SEL_W'(KEY_WORDS);

  phx_st_e           st, st_n;
  logic              fresh, fresh_n;
  logic              key_ok, keyok_n;
  logic [IW-1:0]     info_q, info_n, info_sat;
  logic [WC_W-1:0]   wcnt;
  logic [BC_W-1:0]   bcnt;
  logic              wclr, winc, bclr, binc;
  logic              req, ready, done_ok, issue;
  logic              ld_n;
  logic [SEL_W-1:0]  sel_n;
  logic [DW-1:0]     bus_n;
  logic [MODE_W-1:0] mode_n;

  phx_cnt #(.W(WC_W)) u_wcnt (
    .clk (clk), .rst (rst), .clr (wclr), .inc (winc), .q (wcnt)
  );

  phx_cnt #(.W(BC_W)) u_bcnt (
    .clk (clk), .rst (rst), .clr (bclr), .inc (binc), .q (bcnt)
  );

  phx_blk_issue u_issue (
    .clk (clk), .rst (rst), .req (req), .done_in (blk_done),
    .go (blk_go), .ready (ready), .done_ok (done_ok)
  );

  assign info_sat = (last_bytes > INFO_W'(INFO_MAX)) ? IW'(INFO_MAX) : last_bytes[IW-1:0];
  assign issue    = req && ready;
  assign binc     = done_ok && ((st == ST_MIX) || (st == ST_INIT) || (st == ST_MAC));

  always_comb begin
    st_n    = st;
    fresh_n = fresh;
    keyok_n = key_ok;
    info_n  = info_q;
    wclr    = 1'b0;
    winc    = 1'b0;
    bclr    = 1'b0;
    req     = 1'b0;
    ld_n    = 1'b0;
    sel_n   = '0;
    bus_n   = '0;
    mode_n  = MD_NONE;
    unique case (st)
      ST_IDLE: begin
        if (en) begin
          wclr = 1'b1;
          st_n = key_ok ? ST_NONCE : ST_KEYIN;
        end
      end
      ST_KEYIN: begin
        ld_n  = 1'b1;
        sel_n = SEL_W'(wcnt);
        bus_n = din;
        winc  = 1'b1;
        if (wcnt == KEY_LAST) begin
          st_n    = ST_MIX;
          fresh_n = 1'b1;
          bclr    = 1'b1;
        end
      end
      ST_NONCE: begin
        if (!en) begin
          st_n = ST_IDLE;
        end else begin
          ld_n  = 1'b1;
          sel_n = SEL_NBASE + SEL_W'(wcnt);
          bus_n = din;
          winc  = 1'b1;
          if (wcnt == NONCE_LAST) begin
            st_n    = ST_INIT;
            fresh_n = 1'b1;
            bclr    = 1'b1;
          end
        end
      end
      ST_MIX: begin
        if (fresh) begin
          ld_n    = 1'b1;
          sel_n   = SEL_Z4;
          bus_n   = DW'(MIX_SEED);
          fresh_n = 1'b0;
        end else begin
          req    = 1'b1;
          mode_n = MD_MIX;
          if (done_ok && (bcnt == MIX_LAST)) begin
            st_n    = ST_INIT;
            fresh_n = 1'b1;
            bclr    = 1'b1;
            keyok_n = 1'b1;
          end
        end
      end
      ST_INIT: begin
        if (fresh) begin
          ld_n    = 1'b1;
          sel_n   = SEL_INIT;
          fresh_n = 1'b0;
        end else begin
          req    = 1'b1;
          mode_n = MD_INIT;
          if (done_ok && (bcnt == INIT_LAST)) begin
            st_n = dec_sel ? ST_DEC : ST_ENC;
            bclr = 1'b1;
          end
        end
      end
      ST_ENC, ST_DEC: begin
        mode_n = (st == ST_DEC) ? MD_DEC : MD_ENC;
        bus_n  = din;
        req    = en;
        if (ready && !en) begin
          st_n    = ST_MAC;
          fresh_n = 1'b1;
          bclr    = 1'b1;
          info_n  = info_sat;
        end
      end
      ST_MAC: begin
        if (fresh) begin
          ld_n    = 1'b1;
          sel_n   = SEL_Z0X;
          bus_n   = DW'(TAG_XOR_C);
          fresh_n = 1'b0;
        end else begin
          req    = 1'b1;
          bus_n  = DW'(info_q);
          mode_n = (bcnt < SKIP_N) ? MD_MACD : MD_TAG;
          if (done_ok && (bcnt == MAC_LAST)) begin
            st_n = ST_DWAIT;
            bclr = 1'b1;
          end
        end
      end
      ST_DWAIT: begin
        if (!en) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      fresh    <= 1'b0;
      key_ok   <= 1'b0;
      info_q   <= '0;
      ld_stb   <= 1'b0;
      ld_sel   <= '0;
      blk_mode <= MD_NONE;
      dp_bus   <= '0;
    end else begin
      st       <= st_n;
      fresh    <= fresh_n;
      key_ok   <= keyok_n;
      info_q   <= info_n;
      ld_stb   <= ld_n;
      ld_sel   <= sel_n;
      blk_mode <= issue ? mode_n : MD_NONE;
      dp_bus   <= (ld_n || issue) ? bus_n : '0;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ld_stb && !blk_go));  // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(ld_stb && blk_go));  // R3
  AST_GO_MODE: assert property (@(posedge clk) disable iff (rst)
    blk_go |-> (blk_mode != MD_NONE));  // R5
  AST_GO_SPACING: assert property (@(posedge clk) disable iff (rst)
    blk_go |=> !blk_go);  // R6
  AST_MAC_WORD: assert property (@(posedge clk) disable iff (rst)
    (blk_go && ((blk_mode == MD_MACD) || (blk_mode == MD_TAG))) |-> (dp_bus <= DW'(INFO_MAX)));  // R8
  AST_KEY_STICKY: assert property (@(posedge clk) disable iff (rst)
    key_ok |=> key_ok);  // R9

endmodule

// File: tb/phx_seq_ctrl_tb.sv
module phx_seq_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        dec_sel = 1'b0;
  logic [2:0]  last_bytes = 3'd0;
  logic [31:0] din = 32'd0;
  logic        blk_done = 1'b0;
  logic        ld_stb;
  logic [3:0]  ld_sel;
  logic        blk_go;
  logic [2:0]  blk_mode;
  logic [31:0] dp_bus;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int rcnt = 0;
  int inj_req = 0;
  int inj_seen = 0;

  phx_seq_ctrl u_dut (
    .clk (clk), .rst (rst), .en (en), .dec_sel (dec_sel),
    .last_bytes (last_bytes), .din (din), .blk_done (blk_done),
    .ld_stb (ld_stb), .ld_sel (ld_sel), .blk_go (blk_go),
    .blk_mode (blk_mode), .dp_bus (dp_bus)
  );

  always #(CLK_P/2) clk = ~clk;

  // datapath stand-in: answers each started block LAT negedges later
  always @(negedge clk) begin
    if (rst) begin
      rcnt = 0;
      blk_done = 1'b0;
      inj_seen = inj_req;
    end else begin
      blk_done = 1'b0;
      if (rcnt != 0) begin
        rcnt = rcnt - 1;
        if (rcnt == 0) blk_done = 1'b1;
      end
      if (inj_req != inj_seen) begin
        blk_done = 1'b1;
        inj_seen = inj_req;
      end
      if (blk_go) rcnt = LAT;
    end
  end

  function automatic logic [31:0] wf(logic [31:0] s, int k);
    return (s ^ (32'(k) * 32'h01030507)) + 32'(k);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_words(int base, int cnt, logic [31:0] seed, string req);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk(!ld_stb && !blk_go, req, "quiet on enable edge", {ld_stb, blk_go}, 0);
    din = wf(seed, 0);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      chk(ld_stb && (ld_sel == 4'(base + k)) && (dp_bus == wf(seed, k)), req, "word load",
          {ld_stb, ld_sel, dp_bus}, {1'b1, 4'(base + k), wf(seed, k)});
      din = wf(seed, k + 1);
    end
  endtask

  task automatic next_evt(output bit got);
    got = 1'b0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (ld_stb || blk_go) begin
        got = 1'b1;
        return;
      end
    end
  endtask

  task automatic expect_ld(logic [3:0] sel, logic [31:0] data, string req);
    bit g;
    next_evt(g);
    chk(g && ld_stb && !blk_go && (ld_sel == sel) && (dp_bus == data), req, "phase load",
        {g, ld_stb, blk_go, ld_sel, dp_bus}, {1'b1, 1'b1, 1'b0, sel, data});
  endtask

  task automatic expect_blk(logic [2:0] mode, logic [31:0] data, string req);
    bit g;
    next_evt(g);
    chk(g && blk_go && !ld_stb && (blk_mode == mode) && (dp_bus == data), req, "block start",
        {g, blk_go, ld_stb, blk_mode, dp_bus}, {1'b1, 1'b1, 1'b0, mode, data});
  endtask

  task automatic quiet(int n, string req);
    bit bad = 1'b0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (ld_stb || blk_go) bad = 1'b1;
    end
    chk(!bad, req, "no activity", bad, 0);
  endtask

  task automatic mix_phase(string req);
    expect_ld(4'd13, 32'd96, req);
    for (int i = 0; i < 8; i++) expect_blk(3'd1, 32'd0, req);  // R3
  endtask

  task automatic msg_body(bit dec, int len, logic [2:0] lb, logic [31:0] seed);
    logic [31:0] info;
    dec_sel = dec;
    last_bytes = lb;
    info = (lb > 3) ? 32'd3 : 32'(lb);
    expect_ld(4'd14, 32'd0, "R4");
    for (int i = 0; i < 8; i++) expect_blk(3'd2, 32'd0, "R4");
    if (len == 0) en = 1'b0;
    else din = wf(seed, 0);
    for (int i = 0; i < len; i++) begin
      expect_blk(dec ? 3'd4 : 3'd3, wf(seed, i), "R5");
      if (i == len - 1) en = 1'b0;
      else din = wf(seed, i + 1);
    end
    expect_ld(4'd12, 32'h912d94f1, "R7");
    for (int i = 0; i < 8; i++) expect_blk(3'd5, info, "R8");
    for (int i = 0; i < 4; i++) expect_blk(3'd6, info, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ld_stb && !blk_go && (blk_mode == 0) && (dp_bus == 0), "R1", "outputs in reset",
        {ld_stb, blk_go, blk_mode, dp_bus}, 0);
    rst = 1'b0;
    quiet(3, "R1");

    load_words(0, 12, 32'h1000_0000, "R2");
    mix_phase("R3");
    msg_body(1'b0, 2, 3'd1, 32'h2000_0000);
    quiet(6, "R9");

    for (int d = 0; d < 2; d++)
      for (int len = 0; len < 4; len++)
        for (int lb = 0; lb < 8; lb++) begin
          load_words(8, 4, 32'h3000_0000 + 32'(d * 4096 + len * 256 + lb), "R9");
          msg_body(d[0], len, 3'(lb), 32'h4000_0000 + 32'(d * 4096 + len * 256 + lb));
          quiet(6, "R9");
        end

    // done-wait hold and stray completion pulses (R9, R12)
    load_words(8, 4, 32'h5000_0000, "R9");
    msg_body(1'b1, 1, 3'd2, 32'h5100_0000);
    en = 1'b1;
    quiet(8, "R9");
    inj_req++;
    quiet(10, "R12");
    en = 1'b0;
    quiet(4, "R9");
    inj_req++;
    quiet(6, "R12");

    // nonce input abandoned midway (R10)
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    din = 32'h6000_0000;
    @(negedge clk);
    chk(ld_stb && (ld_sel == 4'd8), "R10", "first nonce word", {ld_stb, ld_sel}, {1'b1, 4'd8});
    din = 32'h6000_0001;
    @(negedge clk);
    chk(ld_stb && (ld_sel == 4'd9), "R10", "second nonce word", {ld_stb, ld_sel}, {1'b1, 4'd9});
    en = 1'b0;
    quiet(5, "R10");
    load_words(8, 4, 32'h6100_0000, "R10");
    msg_body(1'b0, 1, 3'd7, 32'h6200_0000);
    quiet(6, "R10");

    // reset in the middle of a data phase (R11)
    load_words(8, 4, 32'h7000_0000, "R11");
    dec_sel = 1'b0;
    expect_ld(4'd14, 32'd0, "R11");
    for (int i = 0; i < 8; i++) expect_blk(3'd2, 32'd0, "R11");
    din = 32'h7100_0000;
    expect_blk(3'd3, 32'h7100_0000, "R11");
    rst = 1'b1;
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ld_stb && !blk_go && (blk_mode == 0) && (dp_bus == 0), "R11", "outputs in reset",
        {ld_stb, blk_go, blk_mode, dp_bus}, 0);
    rst = 1'b0;
    quiet(4, "R11");
    load_words(0, 12, 32'h7200_0000, "R11");
    mix_phase("R11");
    msg_body(1'b1, 3, 3'd5, 32'h7300_0000);
    quiet(6, "R11");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule